// File: doc/BRIEF.md
# Port-Change Interrupt Generator

This block produces the change-detect interrupt of a 16-bit GPIO expander that sits on an I2C bus. The pins form two 8-bit ports. Each port keeps a reference snapshot of its pin levels, and that snapshot is the value the host last read. While any pin in input mode differs from its snapshot, the block pulls the shared interrupt line low. No latch records the cause. If the pin returns to its snapshot level, the request goes away by itself, and the host learns only that something changed.

A separate bus slave decodes the serial protocol and supplies single-cycle strobes. One strobe per port marks the acknowledge slot of a read of that port, and another marks a Stop condition. A port's read strobe loads that port's snapshot from the synchronized pins. A Stop loads both snapshots. The pins pass through a multi-flop synchronizer before they are compared. A snapshot loads the value that the synchronizer output takes at the same clock edge. As a result, a change that reaches the comparison in the same cycle as a clear strobe goes into the new snapshot and never raises the interrupt. This is the lost-interrupt window of such expanders.

Top module: `portchg_irq`

## Requirements
- R1: While reset is low, `irq_oe_o` is 0 and `snap_o` is 0. After reset is released, the block waits SYNC_STAGES clock edges (2 by default). During that time it loads every snapshot from the synchronized pins and keeps `irq_oe_o` at 0. From then on, `snap_o` equals the pin levels and `irq_oe_o` is 0 for unchanged pins.
- R2: When an input-mode pin changes in either direction, the comparison sees the new level SYNC_STAGES rising edges later. From that point `irq_oe_o` is 1 (the line is pulled low). Pin i belongs to port i/8, and bit 1 of `dir_in_i[i]` means input.
- R3: A pin whose `dir_in_i` bit is 0 (output mode) never causes `irq_oe_o` to be 1, whatever its level.
- R4: If a changed pin returns to its snapshot level and nothing else differs, `irq_oe_o` goes back to 0 once the return has passed the synchronizer. No strobe is needed.
- R5: A read strobe `rd_ack_i[p]` sampled at a rising edge loads `snap_o[8p+7:8p]` with the synchronized pin levels of port p as they stand after that edge. This removes port p's contribution to the interrupt.
- R6: A read strobe for one port leaves the other port's snapshot unchanged. A change that is still pending on the other port keeps `irq_oe_o` at 1.
- R7: `stop_i` sampled at a rising edge loads both snapshots from the synchronized pins as they stand after that edge. This clears the whole interrupt.
- R8: Switching a pin from output to input while its level differs from its snapshot sets `irq_oe_o` to 1 in the same cycle. This is not suppressed.
- R9: While no strobe is present, the snapshots hold their values (bus traffic for other devices produces no strobe), and a pending interrupt stays asserted.
- R10: If a pin change reaches the synchronizer output in the same cycle as that port's read strobe, the change is captured into the snapshot and `irq_oe_o` never becomes 1 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| pin_i | input | 16 | Raw pin levels; bits 7:0 are port 0, bits 15:8 are port 1 |
| dir_in_i | input | 16 | Per-pin mode: 1 input, 0 output |
| rd_ack_i | input | 2 | One-cycle strobe per port at the acknowledge slot of a read of that port |
| stop_i | input | 1 | One-cycle strobe on a Stop condition addressed to this device |
| snap_o | output | 16 | Reference snapshots, read back by the host |
| irq_oe_o | output | 1 | 1 drives the open-drain interrupt line low (external pull-up) |

## Verification
The assertions assume the following about the strobes. They come from a bus slave that has already filtered traffic to other devices. They are sampled synchronously, and they can arrive in any combination, including both reads together with a Stop. The checks on snapshot retention apply only after the post-reset warm-up, because the snapshots are loaded every cycle during it. The stimulus changes pins, directions and strobes only at the falling clock edge. Each change therefore reaches the synchronizer as a clean level, and the number of cycles until it is seen can be counted exactly. The stimulus also places one pin change so that it reaches the comparison in the same cycle as a read strobe.

// File: rtl/portchg_pkg.sv
package portchg_pkg;
  parameter int unsigned DEF_PORTS       = 2;
  parameter int unsigned DEF_PORT_W      = 8;
  parameter int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [0:0] {
    ARM_WARM  = 1'b0,
    ARM_READY = 1'b1
  } arm_state_e;
endpackage

// File: rtl/portchg_sync.sv
module portchg_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_next_o
);
  logic [W-1:0] stg   [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg[i] <= stg_d[i];
    end
  end

  // Output of the last stage and the value it takes at the coming edge.
  assign q_o      = stg[STAGES-1];
  assign q_next_o = stg[STAGES-2];
endmodule

// File: rtl/portchg_arm.sv
module portchg_arm
  import portchg_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic load_all_o,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(STAGES + 1);
  localparam logic [CW-1:0] LAST = CW'(STAGES - 1);

  arm_state_e    state, state_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    cnt_en  = 1'b0;
    if (state == ARM_WARM) begin
      cnt_en = 1'b1;
      cnt_d  = cnt + CW'(1);
      if (cnt == LAST) state_d = ARM_READY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ARM_WARM;
      cnt   <= '0;
    end else begin
      state <= state_d;
      if (cnt_en) cnt <= cnt_d;
    end
  end

  assign load_all_o = (state == ARM_WARM);
  assign armed_o    = (state == ARM_READY);
endmodule

// File: rtl/portchg_port.sv
module portchg_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_q_i,
  input  logic [W-1:0] sync_next_i,
  input  logic [W-1:0] dir_in_i,
  input  logic         load_i,
  input  logic         armed_i,
  output logic [W-1:0] snap_o,
  output logic         pend_o
);
  logic [W-1:0] snap, snap_d;
  logic         snap_en;
  logic [W-1:0] moved;

  always_comb begin
    snap_en = load_i;
    snap_d  = sync_next_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap <= '0;
    else if (snap_en) snap <= snap_d;
  end

  always_comb begin
    moved  = (sync_q_i ^ snap) & dir_in_i;
    pend_o = armed_i & (|moved);
  end

  assign snap_o = snap;
endmodule

// File: rtl/portchg_irq.sv
module portchg_irq
  import portchg_pkg::*;
#(
  parameter int unsigned PORTS       = DEF_PORTS,
  parameter int unsigned PORT_W      = DEF_PORT_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PORTS*PORT_W-1:0]  pin_i,
  input  logic [PORTS*PORT_W-1:0]  dir_in_i,
  input  logic [PORTS-1:0]         rd_ack_i,
  input  logic                     stop_i,
  output logic [PORTS*PORT_W-1:0]  snap_o,
  output logic                     irq_oe_o
);
  localparam int unsigned N = PORTS * PORT_W;

  logic [N-1:0]     sync_q, sync_next;
  logic             load_all, armed;
  logic [PORTS-1:0] pend;

  portchg_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      (pin_i),
    .q_o      (sync_q),
    .q_next_o (sync_next)
  );

  portchg_arm #(.STAGES(SYNC_STAGES)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_all_o (load_all),
    .armed_o    (armed)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic load_p;
    assign load_p = rd_ack_i[p] | stop_i | load_all;

    portchg_port #(.W(PORT_W)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_q_i    (sync_q[p*PORT_W +: PORT_W]),
      .sync_next_i (sync_next[p*PORT_W +: PORT_W]),
      .dir_in_i    (dir_in_i[p*PORT_W +: PORT_W]),
      .load_i      (load_p),
      .armed_i     (armed),
      .snap_o      (snap_o[p*PORT_W +: PORT_W]),
      .pend_o      (pend[p])
    );
  end

  assign irq_oe_o = |pend;
endmodule

// File: rtl/portchg_irq_chk.sv
module portchg_irq_chk #(
  parameter int unsigned PORTS  = 2,
  parameter int unsigned PORT_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [PORTS*PORT_W-1:0] pin_sync,
  input logic [PORTS*PORT_W-1:0] dir_in_i,
  input logic [PORTS-1:0]        rd_ack_i,
  input logic                    stop_i,
  input logic [PORTS*PORT_W-1:0] snap_o,
  input logic                    irq_oe_o,
  input logic                    armed
);
  // R1: silent until the snapshots have been seeded
  a_r1_quiet_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !irq_oe_o);

  // R3: no input-mode pins means no request
  a_r3_outputs_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in_i == '0) |-> !irq_oe_o);

  // R7: a Stop reloads every snapshot
  a_r7_stop_reload: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (snap_o == pin_sync));

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    // R5: a read of port p seeds its snapshot with the synchronized level
    a_r5_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack_i[p] |=> (snap_o[p*PORT_W +: PORT_W] == pin_sync[p*PORT_W +: PORT_W]));

    // R6 and R9: without its own strobe a port's snapshot holds
    a_r6_port_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !rd_ack_i[p] && !stop_i) |=> $stable(snap_o[p*PORT_W +: PORT_W]));
  end
endmodule

bind portchg_irq portchg_irq_chk #(.PORTS(PORTS), .PORT_W(PORT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_sync (sync_q),
  .dir_in_i (dir_in_i),
  .rd_ack_i (rd_ack_i),
  .stop_i   (stop_i),
  .snap_o   (snap_o),
  .irq_oe_o (irq_oe_o),
  .armed    (armed)
);

// File: tb/portchg_irq_tb.sv
module portchg_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int W   = 8;
  localparam int STG = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [N-1:0] pin_r = '0;
  logic [N-1:0] dir_r = '1;
  logic [1:0]   rd_r = '0;
  logic         stop_r = 1'b0;
  logic [N-1:0] snap_o;
  logic         irq_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state: synchronizer as a queue, index 0 is the compared value
  logic [N-1:0] pipe[$];
  logic [N-1:0] m_snap;
  int           warm;

  always #(CLK_PERIOD/2) clk = ~clk;

  portchg_irq u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_r),
    .dir_in_i (dir_r),
    .rd_ack_i (rd_r),
    .stop_i   (stop_r),
    .snap_o   (snap_o),
    .irq_oe_o (irq_oe_o)
  );

  task automatic model_reset();
    pipe.delete();
    for (int i = 0; i < STG; i++) pipe.push_back('0);
    m_snap = '0;
    warm   = 0;
  endtask

  function automatic logic model_irq();
    return (warm >= STG) && (((pipe[0] ^ m_snap) & dir_r) != '0);
  endfunction

  task automatic model_edge();
    logic [N-1:0] nxt;
    if (!rst_n) begin
      model_reset();
    end else begin
      nxt = pipe[1];
      if (warm < STG || stop_r) m_snap = nxt;
      else begin
        for (int p = 0; p < 2; p++)
          if (rd_r[p]) m_snap[p*W +: W] = nxt[p*W +: W];
      end
      pipe.push_back(pin_r);
      void'(pipe.pop_front());
      if (warm < STG) warm++;
    end
  endtask

  task automatic compare(input string tag);
    logic exp_irq;
    exp_irq = model_irq();
    checks++;
    if (irq_oe_o !== exp_irq || snap_o !== m_snap) begin
      fails++;
      $display("FAIL %s: irq=%b snap=%h expected irq=%b snap=%h",
               tag, irq_oe_o, snap_o, exp_irq, m_snap);
    end
  endtask

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs held from one falling edge to the next
  task automatic step(input logic [1:0] rd, input logic st, input string tag);
    rd_r   = rd;
    stop_r = st;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    rd_r   = '0;
    stop_r = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    pin_r = 16'hA5C3;
    dir_r = 16'hFFFF;
    model_reset();
    #1 rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(2'b00, 1'b0, "R1");
    chk("R1 reset irq", {15'd0, irq_oe_o}, 16'd0);
    chk("R1 reset snap", snap_o, 16'h0000);

    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(2'b00, 1'b0, "R1");
    chk("R1 seeded snap", snap_o, 16'hA5C3);
    chk("R1 idle irq", {15'd0, irq_oe_o}, 16'd0);

    // R2: rising edge on port 0 bit 3, seen after two edges
    pin_r = pin_r ^ 16'h0008;
    step(2'b00, 1'b0, "R2");
    chk("R2 one edge", {15'd0, irq_oe_o}, 16'd0);
    step(2'b00, 1'b0, "R2");
    chk("R2 two edges", {15'd0, irq_oe_o}, 16'd1);

    // R4: return to snapshot level clears without a strobe
    pin_r = pin_r ^ 16'h0008;
    step(2'b00, 1'b0, "R4");
    step(2'b00, 1'b0, "R4");
    chk("R4 self clear", {15'd0, irq_oe_o}, 16'd0);

    // R2: falling edge on port 1 bit 10
    pin_r = pin_r & ~16'h0400;
    step(2'b00, 1'b0, "R2");
    step(2'b00, 1'b0, "R2");
    chk("R2 falling", {15'd0, irq_oe_o}, 16'd1);

    // R9: no strobes, state holds
    for (int i = 0; i < 5; i++) step(2'b00, 1'b0, "R9");
    chk("R9 irq held", {15'd0, irq_oe_o}, 16'd1);
    chk("R9 snap held", snap_o, 16'hA5C3);

    // R6: reading port 0 leaves port 1 pending
    step(2'b01, 1'b0, "R6");
    chk("R6 irq kept", {15'd0, irq_oe_o}, 16'd1);
    chk("R6 port1 snap", {8'd0, snap_o[15:8]}, 16'h00A5);

    // R5: reading port 1 clears it
    step(2'b10, 1'b0, "R5");
    chk("R5 irq cleared", {15'd0, irq_oe_o}, 16'd0);
    chk("R5 snap", snap_o, 16'hA1C3);

    // R3: port 0 in output mode, toggling its pins does nothing
    dir_r = 16'hFF00;
    pin_r = pin_r ^ 16'h00FF;
    for (int i = 0; i < 3; i++) step(2'b00, 1'b0, "R3");
    chk("R3 out toggle", {15'd0, irq_oe_o}, 16'd0);
    pin_r = pin_r ^ 16'h0055;
    for (int i = 0; i < 3; i++) step(2'b00, 1'b0, "R3");
    chk("R3 out toggle 2", {15'd0, irq_oe_o}, 16'd0);

    // R8: back to input with a differing level raises the request
    dir_r = 16'hFFFF;
    step(2'b00, 1'b0, "R8");
    chk("R8 dir switch", {15'd0, irq_oe_o}, 16'd1);

    // R7: Stop reloads both ports
    step(2'b00, 1'b1, "R7");
    chk("R7 irq", {15'd0, irq_oe_o}, 16'd0);
    chk("R7 snap", snap_o, pin_r);

    // R10: change reaches the comparison in the same cycle as the read
    pin_r = pin_r ^ 16'h0100;
    step(2'b00, 1'b0, "R10");
    chk("R10 before", {15'd0, irq_oe_o}, 16'd0);
    step(2'b10, 1'b0, "R10");
    chk("R10 captured irq", {15'd0, irq_oe_o}, 16'd0);
    chk("R10 captured snap", snap_o, pin_r);
    for (int i = 0; i < 3; i++) step(2'b00, 1'b0, "R10");
    chk("R10 stays quiet", {15'd0, irq_oe_o}, 16'd0);

    // R6: port 1 read cannot clear a port 0 change
    pin_r = pin_r ^ 16'h2001;
    step(2'b00, 1'b0, "R6");
    step(2'b00, 1'b0, "R6");
    step(2'b10, 1'b0, "R6");
    chk("R6 port0 pending", {15'd0, irq_oe_o}, 16'd1);
    step(2'b01, 1'b0, "R5");
    chk("R5 port0 read", {15'd0, irq_oe_o}, 16'd0);
    chk("R5 final snap", snap_o, pin_r);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule